// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block sits beside an I2C controller and watches the two bus wires. Each wire passes through a two-flop synchroniser and a three-sample filter. Edge logic then finds start and stop conditions and counts rising SCL edges inside each nine-clock frame. The first frame after a start carries the seven address bits and the direction bit on clocks 1 to 8. Every later frame carries eight data bits. Clock 9 of every frame is the acknowledge slot, which is normally driven by whichever side received the byte. Two sticky flags record whether the most recent bus condition was a start or a stop.

The block can also put a start onto the bus for the controller. A one-cycle request from the control logic is held pending until the bus is free. The bus counts as free when the stop flag is set and both filtered lines are high. The block then pulls SDA low, then also pulls SCL low, and then releases both lines. After that release, a slave may keep SCL low to insert a wait. If SCL stays low for more than a programmable number of cycles, a wait indication is raised.

The block has no streaming data path, so all of its pins are plain level or strobe signals.

Top module: `i2c_cond_mon`

## Requirements
- R1: When SDA falls while SCL is high, start_seen becomes 1 and stop_seen becomes 0.
- R2: When SDA rises while SCL is high, stop_seen becomes 1, start_seen becomes 0 and bit_pos returns to 0. The two flags are never 1 at the same time.
- R3: An SDA change while SCL is low changes neither flag nor bit_pos.
- R4: An SDA pulse that lasts fewer than three clock cycles while SCL is high is ignored, and neither flag changes.
- R5: bit_pos is 0 after a start or a stop. Each rising SCL edge adds one, and an edge taken while bit_pos is 9 sets it to 1. bit_pos never exceeds 9.
- R6: ack_slot is high for exactly one cycle on the rising SCL edge that takes bit_pos to 9.
- R7: addr_frame is 1 from a start through clock 9 of the first frame. It is cleared by the next rising SCL edge.
- R8: A repeated start (a start with no stop before it) sets bit_pos to 0 and addr_frame to 1.
- R9: A start_req pulse taken while stop_seen is 0 sets start_pending to 1 and drives neither line. The start is issued only once stop_seen is 1 and both filtered lines are high, and start_pending clears on issue.
- R10: An issued start drives sda_oe for HOLD cycles before scl_oe is asserted. It then holds both for HOLD cycles and releases both together.
- R11: After the block releases SCL, wait_ind rises once SCL has stayed low for more than wait_limit cycles. It falls as soon as SCL is seen high.
- R12: After reset, start_seen, stop_seen, bit_pos, ack_slot, addr_frame, start_pending, sda_oe, scl_oe and wait_ind are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| start_req | input | 1 | One-cycle start request from control logic |
| wait_limit | input | 8 | Maximum low time of SCL, in cycles, before wait_ind |
| start_seen | output | 1 | Sticky flag: last condition was a start |
| stop_seen | output | 1 | Sticky flag: last condition was a stop |
| bit_pos | output | 4 | Clock index within the current frame, 0 to 9 |
| ack_slot | output | 1 | One-cycle strobe when clock 9 begins |
| addr_frame | output | 1 | High during the address frame |
| start_pending | output | 1 | A start request is waiting for a free bus |
| sda_oe | output | 1 | Pull SDA low (open-drain enable) |
| scl_oe | output | 1 | Pull SCL low (open-drain enable) |
| wait_ind | output | 1 | SCL is held low past wait_limit after release |

## Verification
The checker assumes that SCL and SDA never change in the same cycle. It also assumes that every intended level is held for at least three cycles after synchronisation. Without these, edge order and filter output would not be defined. The bench meets both assumptions by changing one wire at a time and holding every bus state for ten cycles. The only exceptions are the deliberately short SDA pulses in the glitch test. The bench models the bus as a wired AND of its own drive and the block's enables. It assumes wait_limit is larger than the filter latency of six cycles and uses a value of 10.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int BIT_W     = 4;
  localparam int FRAME_LEN = 9;
  typedef enum logic [1:0] {GEN_IDLE, GEN_SDA, GEN_BOTH} gen_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  logic [SYNC-1:0] sy;
  logic [FILT-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '1;
      hist <= '1;
      filt <= 1'b1;
    end else begin
      sy   <= {sy[SYNC-2:0], raw};
      hist <= {hist[FILT-2:0], sy[SYNC-1]};
      if (hist == '1)      filt <= 1'b1;
      else if (hist == '0) filt <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  output logic             start_seen,
  output logic             stop_seen,
  output logic [BIT_W-1:0] bit_pos,
  output logic             ack_slot,
  output logic             addr_frame
);
  logic scl_q, sda_q;
  logic start_ev, stop_ev, scl_rise;

  assign start_ev = scl && scl_q && sda_q && !sda;
  assign stop_ev  = scl && scl_q && !sda_q && sda;
  assign scl_rise = scl && !scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      bit_pos    <= '0;
      ack_slot   <= 1'b0;
      addr_frame <= 1'b0;
    end else begin
      scl_q    <= scl;
      sda_q    <= sda;
      ack_slot <= scl_rise && (bit_pos == BIT_W'(FRAME_LEN - 1));
      if (start_ev) begin
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
        bit_pos    <= '0;
        addr_frame <= 1'b1;
      end else if (stop_ev) begin
        start_seen <= 1'b0;
        stop_seen  <= 1'b1;
        bit_pos    <= '0;
        addr_frame <= 1'b0;
      end else if (scl_rise) begin
        if (bit_pos == BIT_W'(FRAME_LEN)) begin
          bit_pos    <= BIT_W'(1);
          addr_frame <= 1'b0;
        end else begin
          bit_pos <= bit_pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_mon_pkg::*;
#(
  parameter int HOLD   = 8,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic              stop_seen,
  input  logic              start_req,
  input  logic [WAIT_W-1:0] wait_limit,
  output logic              start_pending,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              wait_ind
);
  localparam int HW = $clog2(HOLD + 1);

  gen_state_e        state;
  logic [HW-1:0]     hcnt;
  logic              issue, scl_oe_q, armed;
  logic [WAIT_W-1:0] wcnt;

  assign issue  = (state == GEN_IDLE) && start_pending && stop_seen && scl && sda;
  assign sda_oe = (state != GEN_IDLE);
  assign scl_oe = (state == GEN_BOTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= GEN_IDLE;
      hcnt          <= '0;
      start_pending <= 1'b0;
    end else begin
      start_pending <= issue ? 1'b0 : (start_pending | start_req);
      case (state)
        GEN_IDLE: if (issue) begin
          state <= GEN_SDA;
          hcnt  <= '0;
        end
        GEN_SDA: if (hcnt == HW'(HOLD - 1)) begin
          state <= GEN_BOTH;
          hcnt  <= '0;
        end else hcnt <= hcnt + 1'b1;
        GEN_BOTH: if (hcnt == HW'(HOLD - 1)) begin
          state <= GEN_IDLE;
          hcnt  <= '0;
        end else hcnt <= hcnt + 1'b1;
        default: state <= GEN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe_q <= 1'b0;
      armed    <= 1'b0;
      wcnt     <= '0;
      wait_ind <= 1'b0;
    end else begin
      scl_oe_q <= scl_oe;
      if (scl) begin
        armed    <= 1'b0;
        wcnt     <= '0;
        wait_ind <= 1'b0;
      end else if (scl_oe_q && !scl_oe) begin
        armed <= 1'b1;
        wcnt  <= '0;
      end else if (armed) begin
        if (wcnt != '1) wcnt <= wcnt + 1'b1;
        if (wcnt > wait_limit) wait_ind <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon
  import i2c_mon_pkg::*;
#(
  parameter int HOLD   = 8,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              start_req,
  input  logic [WAIT_W-1:0] wait_limit,
  output logic              start_seen,
  output logic              stop_seen,
  output logic [BIT_W-1:0]  bit_pos,
  output logic              ack_slot,
  output logic              addr_frame,
  output logic              start_pending,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              wait_ind
);
  logic [1:0] raw_lines, clean_lines;
  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.SYNC(2), .FILT(3)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .filt(clean_lines[g])
    );
  end

  i2c_cond_detect u_det (
    .clk(clk), .rst_n(rst_n), .scl(clean_lines[0]), .sda(clean_lines[1]),
    .start_seen(start_seen), .stop_seen(stop_seen), .bit_pos(bit_pos),
    .ack_slot(ack_slot), .addr_frame(addr_frame)
  );

  i2c_start_gen #(.HOLD(HOLD), .WAIT_W(WAIT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .scl(clean_lines[0]), .sda(clean_lines[1]),
    .stop_seen(stop_seen), .start_req(start_req), .wait_limit(wait_limit),
    .start_pending(start_pending), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .wait_ind(wait_ind)
  );
endmodule

// File: rtl/i2c_cond_mon_chk.sv
module i2c_cond_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_seen,
  input logic       stop_seen,
  input logic [3:0] bit_pos,
  input logic       ack_slot,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       wait_ind
);
  // R2
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));
  // R5
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= 4'd9);
  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_slot |=> !ack_slot);
  // R6
  ack_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_slot |-> bit_pos == 4'd9);
  // R9
  issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(stop_seen));
  // R10
  sda_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> sda_oe && $past(sda_oe));
  // R11
  wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ind |-> !scl_oe);
endmodule

bind i2c_cond_mon i2c_cond_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
  .bit_pos(bit_pos), .ack_slot(ack_slot), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .wait_ind(wait_ind)
);

// File: tb/i2c_cond_mon_test.sv
module i2c_cond_mon_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_scl = 1'b1, ext_sda = 1'b1, start_req = 1'b0;
  logic [7:0] wait_limit = 8'd10;
  logic start_seen, stop_seen, ack_slot, addr_frame, start_pending;
  logic sda_oe, scl_oe, wait_ind;
  logic [3:0] bit_pos;
  int tests = 0, fails = 0, ack_cnt = 0, cyc = 0, sda_first = -1, scl_first = -1;

  always #10 clk = ~clk;

  i2c_cond_mon uut (
    .clk(clk), .rst_n(rst_n), .scl_in(ext_scl & ~scl_oe), .sda_in(ext_sda & ~sda_oe),
    .start_req(start_req), .wait_limit(wait_limit), .start_seen(start_seen),
    .stop_seen(stop_seen), .bit_pos(bit_pos), .ack_slot(ack_slot),
    .addr_frame(addr_frame), .start_pending(start_pending), .sda_oe(sda_oe),
    .scl_oe(scl_oe), .wait_ind(wait_ind)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ack_slot) ack_cnt <= ack_cnt + 1;
    if (sda_oe && sda_first < 0) sda_first <= cyc;
    if (scl_oe && scl_first < 0) scl_first <= cyc;
  end

  // {scl, sda, start_seen, stop_seen, bit_pos}
  localparam logic [7:0] VEC [12] = '{
    8'b1100_0000, 8'b1010_0000, 8'b0010_0000, 8'b1010_0001,
    8'b0010_0001, 8'b0110_0001, 8'b1110_0010, 8'b0110_0010,
    8'b0010_0010, 8'b1010_0011, 8'b1101_0000, 8'b1101_0000
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_scl();
    ext_scl = 1'b1; hold(10);
    ext_scl = 1'b0; hold(10);
  endtask

  task automatic bus_start_stop();
    ext_sda = 1'b0; hold(10);
    ext_sda = 1'b1; hold(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    hold(3);
    // R12 reset state
    chk("R12 flags", {start_seen, stop_seen, ack_slot, addr_frame}, 0);
    chk("R12 gen", {start_pending, sda_oe, scl_oe, wait_ind, bit_pos}, 0);
    rst_n = 1'b1; hold(3);

    // table: R1 start, R3 sda while scl low, R5 counting, R2 stop
    for (int i = 0; i < 12; i++) begin
      ext_scl = VEC[i][7]; ext_sda = VEC[i][6];
      hold(10);
      chk("R1/R2 flags", {start_seen, stop_seen}, int'(VEC[i][5:4]));
      chk("R3/R5 bit_pos", bit_pos, int'(VEC[i][3:0]));
    end

    // R4 short glitches while idle after stop
    ext_sda = 1'b0; hold(1); ext_sda = 1'b1; hold(10);
    chk("R4 glitch1", {start_seen, stop_seen}, 1);
    ext_sda = 1'b0; hold(2); ext_sda = 1'b1; hold(10);
    chk("R4 glitch2", {start_seen, stop_seen}, 1);

    // frames: R5 R6 R7
    ext_sda = 1'b0; hold(10); ext_scl = 1'b0; hold(10);
    chk("R7 addr after start", addr_frame, 1);
    ack_cnt = 0;
    for (int k = 0; k < 8; k++) pulse_scl();
    chk("R5 pos8", bit_pos, 8);
    chk("R6 no ack yet", ack_cnt, 0);
    pulse_scl();
    chk("R5 pos9", bit_pos, 9);
    chk("R6 one ack", ack_cnt, 1);
    chk("R7 addr thru ack", addr_frame, 1);
    pulse_scl();
    chk("R5 wrap", bit_pos, 1);
    chk("R7 addr cleared", addr_frame, 0);
    for (int k = 0; k < 8; k++) pulse_scl();
    chk("R6 second ack", ack_cnt, 2);
    pulse_scl();
    chk("R5 pos1 again", bit_pos, 1);

    // R8 repeated start
    ext_sda = 1'b1; hold(10); ext_scl = 1'b1; hold(10);
    ext_sda = 1'b0; hold(10);
    chk("R8 pos", bit_pos, 0);
    chk("R8 addr", addr_frame, 1);
    chk("R8 flags", {start_seen, stop_seen}, 2);

    // R9 request while busy (start_seen=1, stop_seen=0)
    @(negedge clk); start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    hold(20);
    chk("R9 pending", start_pending, 1);
    chk("R9 no drive", {sda_oe, scl_oe}, 0);
    sda_first = -1; scl_first = -1;
    ext_sda = 1'b1; hold(60);
    chk("R9 cleared", start_pending, 0);
    chk("R9 issued", sda_first >= 0, 1);
    chk("R10 order", (scl_first - sda_first) == 8, 1);
    chk("R10 released", {sda_oe, scl_oe}, 0);
    chk("R1 own start", {start_seen, stop_seen}, 2);
    chk("R11 no wait", wait_ind, 0);

    // R11 stretch after release
    bus_start_stop();
    @(negedge clk); start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    wait (scl_oe == 1'b1);
    @(negedge clk); ext_scl = 1'b0;
    hold(40);
    chk("R11 wait high", wait_ind, 1);
    ext_scl = 1'b1; hold(12);
    chk("R11 wait low", wait_ind, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule